// File: doc/BRIEF.md
# Round-Robin Burst Receive Scheduler

This block is the receive side of a 32-bit packet interface in which the PHY pushes data toward the link layer. Four port FIFOs are filled through a push port. The scheduler visits them in ascending numerical order and wraps around. It serves a port only when that port is not almost empty. The block announces each transfer with one start-of-transfer cycle that carries the port index on the data bus. It then streams words with start, end, error, modulus, valid and odd-parity signals.

A transfer ends for one of three reasons:
- the configured burst limit has been sent;
- the port FIFO runs empty;
- a packet end is sent that leaves the FIFO almost empty.

A programmable gap of 0 to 7 valid-low cycles follows every packet end and every transfer end. The link layer can hold the stream with an enable input. While the enable is low, no word is lost.

Top module: `rx_burst_sched`

## Requirements
- R1: While and after reset, rval_o, rsx_o, rsop_o, reop_o, rerr_o are 0, rmod_o and rdata_o are 0, and rprty_o is 1.
- R2: A port is eligible when its stored word count exceeds cfg_ae_level_i or it holds at least one end-of-packet word. A port that is not eligible is never selected.
- R3: Eligible ports are served in ascending index order, wrapping from 3 to 0. The search starts at the port after the one served last, and at port 0 after reset.
- R4: Each transfer begins with exactly one rsx_o cycle in which rval_o is 0 and rdata_o holds the port index zero-extended. Data words of that port follow.
- R5: A transfer ends once cfg_max_burst_i words (1 to 64) have been sent.
- R6: A transfer ends when the word sent was the last one stored in the port FIFO. Word counts are taken before any push in the same cycle.
- R7: A word with reop_o ends the transfer if, after it is removed, the port holds cfg_ae_level_i words or fewer and no end-of-packet word. Otherwise the same port continues without a new rsx_o cycle.
- R8: With gap setting G (cfg_gap_i), rval_o is low for exactly G cycles after a packet end that does not end the transfer. Between the last word of one transfer and the first word of the next, rval_o is low for exactly G+2 cycles when the next port is ready.
- R9: While en_i is 0, rval_o is 0 and no word is consumed. The stream resumes with the same word.
- R10: rprty_o makes the count of ones over rdata_o and rprty_o odd on every cycle.
- R11: Per port, words appear with the data, sop, eop, err and mod values with which they were pushed, in push order. The flag and mod outputs are 0 whenever rval_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_valid_i | input | 1 | Write one word into the FIFO selected by push_port_i |
| push_port_i | input | 2 | Destination port of the pushed word |
| push_data_i | input | 32 | Pushed data word |
| push_sop_i | input | 1 | Pushed word starts a packet |
| push_eop_i | input | 1 | Pushed word ends a packet |
| push_err_i | input | 1 | Pushed packet is errored |
| push_mod_i | input | 2 | Pushed modulus for the final word |
| fifo_full_o | output | 4 | Per-port FIFO full |
| cfg_ae_level_i | input | 5 | Almost-empty level in words |
| cfg_max_burst_i | input | 7 | Maximum burst in words, 1 to 64 |
| cfg_gap_i | input | 3 | Valid-low gap in cycles, 0 to 7 |
| en_i | input | 1 | Link layer enable; 0 pauses the data stream |
| rdata_o | output | 32 | Data bus: port index on rsx_o cycles, data otherwise |
| rprty_o | output | 1 | Odd parity over rdata_o |
| rsop_o | output | 1 | Start of packet |
| reop_o | output | 1 | End of packet |
| rerr_o | output | 1 | Packet error |
| rmod_o | output | 2 | Modulus of the final word |
| rval_o | output | 1 | Data word valid |
| rsx_o | output | 1 | Start of transfer, port index on rdata_o |

## Verification
Two functions can act on the same word: the burst-limit count and the packet-end decision. Both can fire on one word. The bench provokes this with a packet whose length equals the burst limit, followed by more data in the same port. It then judges that only one gap plus the address overhead (G+2 low cycles) separates the two transfers, that a new rsx_o cycle appears, and that no extra packet-end gap is inserted. The almost-empty termination is also contrasted with continuation across a packet end at a lower level.

// File: rtl/rx_sched_pkg.sv
package rx_sched_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MOD_W  = 2;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sop;
    logic              eop;
    logic              err;
    logic [MOD_W-1:0]  mod;
  } rx_word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_GAP
  } sched_state_e;
endpackage

// File: rtl/rx_port_fifo.sv
module rx_port_fifo
  import rx_sched_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  rx_word_t         wdata_i,
  input  logic             pop_i,
  output rx_word_t         head_o,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] eop_cnt_o,
  output logic             full_o
);
  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q, eop_q;
  logic             do_push, do_pop;

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (lvl_q != '0);
  assign head_o    = mem_q[rd_q];
  assign level_o   = lvl_q;
  assign eop_cnt_o = eop_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      eop_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
      eop_q <= eop_q + LVL_W'(do_push && wdata_i.eop) - LVL_W'(do_pop && head_o.eop);
    end
  end
endmodule

// File: rtl/rx_rr_arbiter.sv
module rx_rr_arbiter #(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic [IDX_W-1:0]     ptr_i,
  output logic [IDX_W-1:0]     gnt_idx_o,
  output logic                 gnt_any_o
);
  // scan from the farthest offset down so the nearest requester wins
  always_comb begin
    gnt_idx_o = '0;
    gnt_any_o = |req_i;
    for (int k = NUM_PORTS - 1; k >= 0; k--) begin
      int unsigned j;
      j = (int'(ptr_i) + k) % NUM_PORTS;
      if (req_i[j]) gnt_idx_o = IDX_W'(j);
    end
  end
endmodule

// File: rtl/rx_burst_ctrl.sv
module rx_burst_ctrl
  import rx_sched_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned BURST_W   = 7,
  parameter int unsigned GAP_W     = 3,
  localparam int unsigned IDX_W = $clog2(NUM_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [LVL_W-1:0]   cfg_ae_level_i,
  input  logic [BURST_W-1:0] cfg_max_burst_i,
  input  logic [GAP_W-1:0]   cfg_gap_i,
  input  logic               gnt_any_i,
  input  logic [IDX_W-1:0]   gnt_idx_i,
  input  logic [LVL_W-1:0]   sel_level_i,
  input  logic [LVL_W-1:0]   sel_eop_cnt_i,
  input  logic               sel_eop_i,
  output sched_state_e       state_o,
  output logic [IDX_W-1:0]   sel_o,
  output logic [IDX_W-1:0]   ptr_o,
  output logic               pop_o
);
  sched_state_e       state_q;
  logic [IDX_W-1:0]   sel_q, ptr_q, next_ptr;
  logic [BURST_W-1:0] burst_q;
  logic [GAP_W-1:0]   gap_q;
  logic               resume_q;
  logic               hit_max, hit_empty, hit_ae, end_xfer;
  logic [LVL_W-1:0]   post_lvl, post_eop;

  assign pop_o    = (state_q == ST_DATA) && en_i;
  assign post_lvl = sel_level_i - 1'b1;
  assign post_eop = sel_eop_cnt_i - LVL_W'(sel_eop_i);
  assign hit_max  = ({1'b0, burst_q} + 1'b1) >= {1'b0, cfg_max_burst_i};
  assign hit_empty = (sel_level_i == LVL_W'(1));
  assign hit_ae   = sel_eop_i && (post_lvl <= cfg_ae_level_i) && (post_eop == '0);
  assign end_xfer = hit_max || hit_empty || hit_ae;
  assign next_ptr = (sel_q == IDX_W'(NUM_PORTS - 1)) ? '0 : sel_q + 1'b1;

  assign state_o = state_q;
  assign sel_o   = sel_q;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      ptr_q    <= '0;
      burst_q  <= '0;
      gap_q    <= '0;
      resume_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (gnt_any_i) begin
          sel_q   <= gnt_idx_i;
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          burst_q <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (en_i) begin
          burst_q <= burst_q + 1'b1;
          if (end_xfer) begin
            ptr_q <= next_ptr;
            if (cfg_gap_i != '0) begin
              gap_q    <= cfg_gap_i;
              resume_q <= 1'b0;
              state_q  <= ST_GAP;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (sel_eop_i && cfg_gap_i != '0) begin
            gap_q    <= cfg_gap_i;
            resume_q <= 1'b1;
            state_q  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q <= GAP_W'(1)) state_q <= resume_q ? ST_DATA : ST_IDLE;
          else                    gap_q   <= gap_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_burst_sched.sv
module rx_burst_sched
  import rx_sched_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned MAX_BURST  = 64,
  parameter int unsigned MAX_GAP    = 7,
  localparam int unsigned IDX_W   = $clog2(NUM_PORTS),
  localparam int unsigned LVL_W   = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned BURST_W = $clog2(MAX_BURST + 1),
  localparam int unsigned GAP_W   = $clog2(MAX_GAP + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_valid_i,
  input  logic [IDX_W-1:0]     push_port_i,
  input  logic [DATA_W-1:0]    push_data_i,
  input  logic                 push_sop_i,
  input  logic                 push_eop_i,
  input  logic                 push_err_i,
  input  logic [MOD_W-1:0]     push_mod_i,
  output logic [NUM_PORTS-1:0] fifo_full_o,
  input  logic [LVL_W-1:0]     cfg_ae_level_i,
  input  logic [BURST_W-1:0]   cfg_max_burst_i,
  input  logic [GAP_W-1:0]     cfg_gap_i,
  input  logic                 en_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rprty_o,
  output logic                 rsop_o,
  output logic                 reop_o,
  output logic                 rerr_o,
  output logic [MOD_W-1:0]     rmod_o,
  output logic                 rval_o,
  output logic                 rsx_o
);
  rx_word_t             wword;
  rx_word_t             head   [NUM_PORTS];
  logic [LVL_W-1:0]     level  [NUM_PORTS];
  logic [LVL_W-1:0]     eopc   [NUM_PORTS];
  logic [NUM_PORTS-1:0] elig;
  logic [IDX_W-1:0]     gnt_idx, sel, ptr;
  logic                 gnt_any, pop;
  sched_state_e         state;
  rx_word_t             sel_head;

  assign wword = '{data: push_data_i, sop: push_sop_i, eop: push_eop_i,
                   err: push_err_i, mod: push_mod_i};

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    rx_port_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (push_valid_i && (push_port_i == IDX_W'(i))),
      .wdata_i  (wword),
      .pop_i    (pop && (sel == IDX_W'(i))),
      .head_o   (head[i]),
      .level_o  (level[i]),
      .eop_cnt_o(eopc[i]),
      .full_o   (fifo_full_o[i])
    );
    assign elig[i] = (level[i] > cfg_ae_level_i) || (eopc[i] != '0);
  end

  rx_rr_arbiter #(.NUM_PORTS(NUM_PORTS)) i_arb (
    .req_i    (elig),
    .ptr_i    (ptr),
    .gnt_idx_o(gnt_idx),
    .gnt_any_o(gnt_any)
  );

  assign sel_head = head[sel];

  rx_burst_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .LVL_W    (LVL_W),
    .BURST_W  (BURST_W),
    .GAP_W    (GAP_W)
  ) i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_i),
    .cfg_ae_level_i (cfg_ae_level_i),
    .cfg_max_burst_i(cfg_max_burst_i),
    .cfg_gap_i      (cfg_gap_i),
    .gnt_any_i      (gnt_any),
    .gnt_idx_i      (gnt_idx),
    .sel_level_i    (level[sel]),
    .sel_eop_cnt_i  (eopc[sel]),
    .sel_eop_i      (sel_head.eop),
    .state_o        (state),
    .sel_o          (sel),
    .ptr_o          (ptr),
    .pop_o          (pop)
  );

  always_comb begin
    rsx_o   = (state == ST_ADDR);
    rval_o  = pop;
    rdata_o = '0;
    if (rsx_o) rdata_o[IDX_W-1:0] = sel;
    else if (state == ST_DATA) rdata_o = sel_head.data;
    rsop_o  = rval_o && sel_head.sop;
    reop_o  = rval_o && sel_head.eop;
    rerr_o  = rval_o && sel_head.err;
    rmod_o  = rval_o ? sel_head.mod : '0;
    rprty_o = ~^rdata_o;
  end
endmodule

// File: rtl/rx_burst_sched_chk.sv
module rx_burst_sched_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BURST_W   = 7,
  parameter int unsigned GAP_W     = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [GAP_W-1:0]   cfg_gap_i,
  input logic [BURST_W-1:0] cfg_max_burst_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               rval_o,
  input logic               rsx_o,
  input logic               reop_o,
  input logic               rsop_o
);
  logic [BURST_W:0] words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) words_q <= '0;
    else if (rsx_o) words_q <= '0;
    else if (rval_o && !(&words_q)) words_q <= words_q + 1'b1;
  end

  assert_rsx_no_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsx_o |-> !rval_o && !rsop_o);
  assert_rsx_port_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsx_o |-> (rdata_o < DATA_W'(NUM_PORTS)));
  assert_rsx_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsx_o |=> !rsx_o);
  assert_pause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !rval_o);
  assert_eop_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rval_o && reop_o && cfg_gap_i != '0) |=> !rval_o);
  assert_burst_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rval_o |-> (words_q < {1'b0, cfg_max_burst_i}));
endmodule

bind rx_burst_sched rx_burst_sched_chk #(
  .NUM_PORTS(NUM_PORTS),
  .DATA_W   (rx_sched_pkg::DATA_W),
  .BURST_W  (BURST_W),
  .GAP_W    (GAP_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .cfg_gap_i      (cfg_gap_i),
  .cfg_max_burst_i(cfg_max_burst_i),
  .rdata_o        (rdata_o),
  .rval_o         (rval_o),
  .rsx_o          (rsx_o),
  .reop_o         (reop_o),
  .rsop_o         (rsop_o)
);

// File: tb/test_rx_burst_sched.sv
`timescale 1ns/1ps
module test_rx_burst_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_v = 1'b0;
  logic [1:0]  push_port = '0;
  logic [31:0] push_data = '0;
  logic        push_sop = 1'b0, push_eop = 1'b0, push_err = 1'b0;
  logic [1:0]  push_mod = '0;
  logic [3:0]  full;
  logic [4:0]  ae = 5'd0;
  logic [6:0]  maxb = 7'd64;
  logic [2:0]  gap = 3'd0;
  logic        en = 1'b0;
  logic [31:0] rdata;
  logic        rprty, rsop, reop, rerr, rval, rsx;
  logic [1:0]  rmod;

  always #10 clk = ~clk;

  rx_burst_sched i_rx_burst_sched (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_v), .push_port_i(push_port),
    .push_data_i(push_data), .push_sop_i(push_sop), .push_eop_i(push_eop),
    .push_err_i(push_err), .push_mod_i(push_mod), .fifo_full_o(full),
    .cfg_ae_level_i(ae), .cfg_max_burst_i(maxb), .cfg_gap_i(gap), .en_i(en),
    .rdata_o(rdata), .rprty_o(rprty), .rsop_o(rsop), .reop_o(reop),
    .rerr_o(rerr), .rmod_o(rmod), .rval_o(rval), .rsx_o(rsx));

  int checks = 0, errors = 0;
  logic [36:0] sb [4][$];
  int xn, xport [64], xlen [64];
  int gn, glow [64], grsx [64], geop [64];
  int mon_port = 0, low_run = 0, words_seen = 0;
  bit rsx_between = 0, prev_eop = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit odd_ok(input logic [31:0] d, input logic p);
    return ($countones({d, p}) % 2) == 1;
  endfunction

  task automatic clear_logs();
    xn = 0; gn = 0; low_run = 0; rsx_between = 0; prev_eop = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(odd_ok(rdata, rprty), "R10 parity", rprty, ~^rdata);
      if (!rval) begin
        if (rsop || reop || rerr || rmod != 0)
          chk(0, "R11 flags idle", {rsop, reop, rerr, rmod}, 0);
        low_run++;
      end
      if (rsx) begin
        chk(rdata < 4, "R4 rsx port", rdata, 3);
        mon_port = rdata[1:0];
        if (xn < 64) begin xport[xn] = mon_port; xlen[xn] = 0; end
        xn++;
        rsx_between = 1;
      end
      if (rval) begin
        logic [36:0] exp_w;
        words_seen++;
        if ((prev_eop || rsx_between) && gn < 64) begin
          glow[gn] = low_run; grsx[gn] = rsx_between; geop[gn] = prev_eop; gn++;
        end
        low_run = 0; rsx_between = 0; prev_eop = reop;
        if (sb[mon_port].size() == 0) chk(0, "R11 unexpected word", rdata, 0);
        else begin
          exp_w = sb[mon_port].pop_front();
          chk({rdata, rsop, reop, rerr, rmod} == exp_w, "R11 word", {rdata, rsop, reop, rerr, rmod}, exp_w);
        end
        if (xn > 0 && xn <= 64) begin
          xlen[xn-1]++;
          chk(xlen[xn-1] <= maxb, "R5 burst length", xlen[xn-1], maxb);
        end
      end
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic push(input int p, input logic [31:0] d, input bit s, input bit e,
                      input bit er, input logic [1:0] m);
    push_v = 1; push_port = p[1:0]; push_data = d;
    push_sop = s; push_eop = e; push_err = er; push_mod = m;
    sb[p].push_back({d, s, e, er, m});
    cyc();
    push_v = 0;
  endtask

  function automatic int total_q();
    return sb[0].size() + sb[1].size() + sb[2].size() + sb[3].size();
  endfunction

  task automatic drain(input int limit);
    for (int i = 0; i < limit && total_q() != 0; i++) cyc();
    cyc(12);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    chk(rval == 0 && rsx == 0 && rsop == 0 && reop == 0 && rerr == 0, "R1 flags in reset", {rval, rsx, rsop, reop, rerr}, 0);
    chk(rdata == 0 && rmod == 0 && rprty == 1, "R1 bus in reset", {rdata, rmod, rprty}, 1);
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk(rval == 0 && rsx == 0 && rdata == 0 && rprty == 1, "R1 after reset", {rval, rsx, rdata, rprty}, 1);

    // R2 R3 R5 R6: all ports loaded below threshold, then released at once
    ae = 5'd15; maxb = 7'd4; gap = 3'd1; en = 1;
    clear_logs();
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 10; w++) push(p, 32'h1000_0000 * (p + 1) + w, w == 0, 0, 0, 0);
    cyc(6);
    chk(xn == 0, "R2 no transfer below level", xn, 0);
    ae = 5'd0;
    drain(400);
    chk(xn == 12, "R3 transfer count", xn, 12);
    for (int i = 0; i < 12 && i < xn; i++) begin
      chk(xport[i] == i % 4, "R3 round robin order", xport[i], i % 4);
      chk(xlen[i] == ((i < 8) ? 4 : 2), (i < 8) ? "R5 max burst end" : "R6 empty end",
          xlen[i], (i < 8) ? 4 : 2);
    end
    for (int i = 1; i < gn; i++) chk(glow[i] == 3, "R8 gap between transfers", glow[i], 3);

    // R7: packet end leaves port almost empty
    ae = 5'd3; maxb = 7'd64; gap = 3'd3; en = 0;
    clear_logs();
    push(1, 32'hA1, 1, 0, 0, 0); push(1, 32'hA2, 0, 0, 0, 0); push(1, 32'hA3, 0, 1, 1, 2);
    push(1, 32'hB1, 1, 0, 0, 0); push(1, 32'hB2, 0, 0, 0, 0);
    en = 1;
    cyc(25);
    chk(xn == 1 && xlen[0] == 3, "R7 end at packet end", xlen[0], 3);
    chk(sb[1].size() == 2, "R2 remainder held", sb[1].size(), 2);
    push(1, 32'hB3, 0, 0, 0, 0); push(1, 32'hB4, 0, 1, 0, 3);
    drain(100);
    chk(xn == 2 && xlen[1] == 4 && xport[1] == 1, "R2 eligible by stored end", xlen[1], 4);

    // R7 R8: continuation across a packet end, gap 5 and gap 0
    for (int g = 5; g >= 0; g -= 5) begin
      ae = 5'd0; gap = g[2:0]; en = 0;
      clear_logs();
      push(2, 32'hC1, 1, 0, 0, 0); push(2, 32'hC2, 0, 1, 0, 1);
      push(2, 32'hC3, 1, 0, 0, 0); push(2, 32'hC4, 0, 0, 0, 0); push(2, 32'hC5, 0, 0, 0, 0);
      en = 1;
      drain(100);
      chk(xn == 1 && xlen[0] == 5, "R7 continue same port", xlen[0], 5);
      chk(gn >= 2 && grsx[1] == 0 && geop[1] == 1, "R7 no rsx after packet end", grsx[1], 0);
      chk(gn >= 2 && glow[1] == g, "R8 packet end gap", glow[1], g);
    end

    // coincidence: burst limit and packet end on the same word
    ae = 5'd0; maxb = 7'd4; gap = 3'd2; en = 0;
    clear_logs();
    for (int w = 0; w < 4; w++) push(3, 32'hD0 + w, w == 0, w == 3, 0, 0);
    for (int w = 0; w < 4; w++) push(3, 32'hE0 + w, w == 0, 0, 0, 0);
    en = 1;
    drain(100);
    chk(xn == 2 && xlen[0] == 4 && xlen[1] == 4, "R5 limit at packet end", xlen[0], 4);
    chk(gn >= 2 && glow[1] == 4 && grsx[1] == 1, "R8 single gap at coincidence", glow[1], 4);
    chk(xport[0] == 3 && xport[1] == 3, "R3 sole eligible port reused", xport[1], 3);

    // R9: pause holds words
    ae = 5'd0; gap = 3'd0; maxb = 7'd64; en = 0;
    clear_logs();
    words_seen = 0;
    push(0, 32'hF1, 1, 0, 0, 0); push(0, 32'hF2, 0, 0, 0, 0); push(0, 32'hF3, 0, 1, 0, 2);
    cyc(6);
    chk(words_seen == 0, "R9 no word while paused", words_seen, 0);
    chk(sb[0].size() == 3, "R9 nothing consumed", sb[0].size(), 3);
    en = 1; cyc(1); en = 0; cyc(4);
    chk(words_seen == 1, "R9 one word per enabled cycle", words_seen, 1);
    en = 1;
    drain(50);
    chk(words_seen == 3, "R9 resume same word", words_seen, 3);

    // random traffic with random pauses
    begin
      int rem [4];
      int seed;
      seed = $urandom(1234);
      for (int p = 0; p < 4; p++) rem[p] = 0;
      ae = 5'd2; maxb = 7'd7;
      for (int c = 0; c < 3000; c++) begin
        int p;
        if (c % 200 == 0) gap = $urandom_range(7, 0);
        en = ($urandom_range(9, 0) < 8);
        p = $urandom_range(3, 0);
        if ($urandom_range(2, 0) != 0 && sb[p].size() < 13) begin
          bit s, e;
          s = (rem[p] == 0);
          if (s) rem[p] = $urandom_range(9, 1);
          rem[p]--;
          e = (rem[p] == 0);
          push(p, $urandom(), s, e, e && ($urandom_range(7, 0) == 0),
               e ? 2'($urandom_range(3, 0)) : 2'd0);
        end else cyc();
      end
      ae = 5'd0; en = 1;
      drain(2000);
      chk(total_q() == 0, "R11 all words delivered", total_q(), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule